// File: doc/BRIEF.md
# Four-Phase Fetch and Execute Sequencer

This block is the instruction front end of a small 8-bit controller core whose instructions are 16 bits wide. Each instruction cycle is split into four clock phases, Q1 to Q4. While one instruction executes, the block fetches the next one. It owns the program counter, the instruction register and the logic that replaces a discarded prefetched word with a forced NOP.

The execute stage sends the block a new program counter when a branch is taken, and a skip request when a conditional test comes out true. Either one makes the block discard the word it has already fetched. Two-word instructions are recognised from their first word, and the following word is marked as an operand cycle. A word whose top nibble is all ones never executes on its own: when it is reached as a standalone instruction, it behaves as a NOP.

The datapath gets the following from this block:
- a one-hot phase vector;
- an execute-enable flag;
- a read strobe in Q2 and a write strobe in Q4;
- flags that show which cycles carry a flushed NOP and which carry an operand word.

Top module: `fx_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the outputs hold these values: `pm_addr` = 0, `ir` = 16'h0000 (the NOP encoding), `phase` = 4'b0001 (Q1), and `flush` and `ext_cycle` are both 0.
- R2: `phase` is one-hot. Bit 0 is Q1 and bit 3 is Q4. It advances Q1→Q2→Q3→Q4→Q1 on every clock.
- R3: `pm_addr`, `ir`, `flush` and `ext_cycle` change only on the edge that leaves Q4. Bit 0 of `pm_addr` is always 0.
- R4: On the edge leaving Q4, with no accepted redirect and no accepted skip, `ir` takes the word that `pm_rdata` presents for the current `pm_addr`, and `pm_addr` increases by 2, wrapping at the width.
- R5: A redirect is accepted when `redirect_valid` is high in Q4 while `exec_en` or `ext_cycle` is 1. In the next cycle `flush` = 1 and `ir` = NOP. `pm_addr` becomes `redirect_pc` with bit 0 cleared. The cycle after that, `ir` holds the word at the target.
- R6: A skip is accepted when `skip_req` is high in Q4 while `exec_en` is 1 and no redirect is accepted. In the next cycle `flush` = 1 and `ir` = NOP, and `pm_addr` increases by 2.
- R7: A first word whose bits 15:12 are 4'b1100, or whose bits 15:10 are 6'b111011, is executed with no redirect or skip accepted. In the next cycle `ext_cycle` = 1, `exec_en` = 0, and `ir` holds the following program word.
- R8: `exec_en` is 0 in these cases:
  - during a flush cycle;
  - during an operand cycle;
  - for any word with bits 15:12 = 4'b1111 that is not in an operand cycle.
  In every other case it is 1.
- R9: `redirect_valid` and `skip_req` have no effect in these cases:
  - when they are not high in Q4;
  - when the current cycle has `exec_en` = 0 and `ext_cycle` = 0.
  In addition, `skip_req` has no effect during an operand cycle.
- R10: `rd_strobe` is high exactly in Q2 of a cycle with `exec_en` = 1. `wr_strobe` is high exactly in Q4 of such a cycle.
- R11: A two-word branch whose redirect is accepted in its operand cycle takes three instruction cycles. The target word is in `ir`, with `exec_en` = 1, three cycles after the first word was executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock; four edges make one instruction cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| pm_addr | output | PC_W | Program memory byte address (program counter) |
| pm_rdata | input | 16 | Program word at `pm_addr`, valid by Q4 |
| redirect_valid | input | 1 | Execute stage requests a new program counter |
| redirect_pc | input | PC_W | Target byte address for a redirect |
| skip_req | input | 1 | Conditional test is true: discard the next word |
| phase | output | 4 | One-hot phase, bit 0 = Q1 |
| ir | output | 16 | Instruction register |
| flush | output | 1 | Current cycle executes a substituted NOP |
| ext_cycle | output | 1 | `ir` holds the operand word of a two-word instruction |
| exec_en | output | 1 | Current `ir` is a real instruction to execute |
| rd_strobe | output | 1 | Data operand read strobe (Q2) |
| wr_strobe | output | 1 | Destination write strobe (Q4) |

## Verification
The assertions assume the following about the inputs:
- `pm_rdata` is a pure function of `pm_addr`, so it is steady over a cycle;
- `redirect_valid` and `skip_req` matter only at the Q4 edge;
- reset is held for at least one clock.

The stimulus keeps to these assumptions. The bench's program memory is an array indexed combinationally by `pm_addr`. The redirect and skip inputs are changed only at falling edges, and redirect and skip are driven at random in every phase, including flush cycles, operand cycles and standalone tail words, so that the ignore rules are exercised. Redirect targets stay inside the 512-byte modelled memory. Odd target values are included on purpose.

// File: rtl/fxs_pkg.sv
package fxs_pkg;

  // Instruction word geometry.
  localparam int unsigned IW = 16;
  localparam int unsigned NPH = 4;
  localparam logic [IW-1:0] NOP_WORD = '0;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  // First word of an instruction that occupies two program words.
  function automatic logic is_long_first(input logic [IW-1:0] w);
    return (w[15:12] == 4'b1100) || (w[15:10] == 6'b111011);
  endfunction

  // Operand word pattern: never executes on its own.
  function automatic logic is_tail_word(input logic [IW-1:0] w);
    return w[15:12] == 4'b1111;
  endfunction

endpackage

// File: rtl/fxs_phase_gen.sv
module fxs_phase_gen #(
  parameter int unsigned NPH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [NPH-1:0] ph_onehot,
  output logic           last_ph
);
  localparam int unsigned CW = (NPH > 1) ? $clog2(NPH) : 1;
  localparam logic [CW-1:0] LAST = CW'(NPH - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + CW'(1);
  end

  for (genvar g = 0; g < NPH; g++) begin : g_dec
    assign ph_onehot[g] = (cnt == CW'(g));
  end

  assign last_ph = ph_onehot[NPH-1];

endmodule

// File: rtl/fxs_pc_unit.sv
module fxs_pc_unit #(
  parameter int unsigned PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_en,
  input  logic            load_tgt,
  input  logic [PC_W-1:0] tgt,
  output logic [PC_W-1:0] pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(2);

  function automatic logic [PC_W-1:0] pc_step(input logic [PC_W-1:0] p);
    return p + STEP;
  endfunction

  function automatic logic [PC_W-1:0] pc_align(input logic [PC_W-1:0] t);
    return {t[PC_W-1:1], 1'b0};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)      pc <= '0;
    else if (adv_en) pc <= load_tgt ? pc_align(tgt) : pc_step(pc);
  end

endmodule

// File: rtl/fxs_ir_unit.sv
module fxs_ir_unit
  import fxs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic          kill,
  input  logic          mark_ext,
  input  logic [IW-1:0] fetched,
  output logic [IW-1:0] ir,
  output logic          flush,
  output logic          ext
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir    <= NOP_WORD;
      flush <= 1'b0;
      ext   <= 1'b0;
    end else if (load_en) begin
      ir    <= kill ? NOP_WORD : fetched;
      flush <= kill;
      ext   <= mark_ext & ~kill;
    end
  end

endmodule

// File: rtl/fx_sequencer.sv
module fx_sequencer
  import fxs_pkg::*;
#(
  parameter int unsigned PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PC_W-1:0] pm_addr,
  input  logic [15:0]     pm_rdata,
  input  logic            redirect_valid,
  input  logic [PC_W-1:0] redirect_pc,
  input  logic            skip_req,
  output logic [3:0]      phase,
  output logic [15:0]     ir,
  output logic            flush,
  output logic            ext_cycle,
  output logic            exec_en,
  output logic            rd_strobe,
  output logic            wr_strobe
);

  // Named internal events, visible to the checker.
  logic last_ph;
  logic take_redirect;
  logic take_skip;
  logic start_ext;
  logic kill_next;

  fxs_phase_gen #(.NPH(NPH)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph_onehot (phase),
    .last_ph   (last_ph)
  );

  // Execute qualification (R8).
  assign exec_en = ~flush & ~ext_cycle & ~is_tail_word(ir);

  // Redirect accepted in an executing or operand cycle (R5, R9).
  assign take_redirect = last_ph & redirect_valid & (exec_en | ext_cycle);

  // Skip accepted only in an executing cycle (R6, R9).
  assign take_skip = last_ph & skip_req & exec_en & ~take_redirect;

  assign kill_next = take_redirect | take_skip;

  // Operand cycle follows a long first word (R7).
  assign start_ext = exec_en & is_long_first(ir);

  fxs_pc_unit #(.PC_W(PC_W)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_en   (last_ph),
    .load_tgt (take_redirect),
    .tgt      (redirect_pc),
    .pc       (pm_addr)
  );

  fxs_ir_unit u_ir (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (last_ph),
    .kill     (kill_next),
    .mark_ext (start_ext),
    .fetched  (pm_rdata),
    .ir       (ir),
    .flush    (flush),
    .ext      (ext_cycle)
  );

  // Data memory strobes (R10).
  assign rd_strobe = phase[1] & exec_en;
  assign wr_strobe = phase[3] & exec_en;

endmodule

// File: rtl/fx_sequencer_chk.sv
module fx_sequencer_chk #(
  parameter int unsigned PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] pm_addr,
  input logic            redirect_valid,
  input logic [PC_W-1:0] redirect_pc,
  input logic            skip_req,
  input logic [3:0]      phase,
  input logic [15:0]     ir,
  input logic            flush,
  input logic            ext_cycle,
  input logic            exec_en,
  input logic            rd_strobe,
  input logic            wr_strobe
);
  localparam logic [PC_W-1:0] EVEN_MASK = ~PC_W'(1);

  p_phase_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase) == 1);

  p_phase_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase[3] |=> phase[0]);

  p_phase_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !phase[3] |=> phase == ($past(phase) << 1));

  p_hold_mid_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !phase[3] |=> ($stable(pm_addr) && $stable(ir) && $stable(flush) && $stable(ext_cycle)));

  p_addr_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pm_addr[0] == 1'b0);

  p_redirect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[3] && redirect_valid && (exec_en || ext_cycle))
    |=> (flush && ir == 16'h0000 && pm_addr == ($past(redirect_pc) & EVEN_MASK)));

  p_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[3] && skip_req && exec_en && !redirect_valid)
    |=> (flush && ir == 16'h0000 && pm_addr == $past(pm_addr) + PC_W'(2)));

  p_operand_noexec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cycle |-> !exec_en);

  p_flush_noexec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !exec_en);

  p_idle_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[3] && !exec_en && !ext_cycle) |=> (!flush && pm_addr == $past(pm_addr) + PC_W'(2)));

  p_rd_then_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> ##2 wr_strobe);

  p_wr_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe && !rd_strobe);

endmodule

bind fx_sequencer fx_sequencer_chk #(.PC_W(PC_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pm_addr        (pm_addr),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .skip_req       (skip_req),
  .phase          (phase),
  .ir             (ir),
  .flush          (flush),
  .ext_cycle      (ext_cycle),
  .exec_en        (exec_en),
  .rd_strobe      (rd_strobe),
  .wr_strobe      (wr_strobe)
);

// File: tb/fx_sequencer_tb.sv
`timescale 1ns/1ps
module fx_sequencer_tb;
  localparam int PC_W = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] pm_addr;
  logic [15:0]     pm_rdata;
  logic            redirect_valid = 1'b0;
  logic [PC_W-1:0] redirect_pc = '0;
  logic            skip_req = 1'b0;
  logic [3:0]      phase;
  logic [15:0]     ir;
  logic            flush, ext_cycle, exec_en, rd_strobe, wr_strobe;

  logic [15:0] prog [256];
  assign pm_rdata = prog[pm_addr[8:1]];

  always #5 clk = ~clk;

  fx_sequencer #(.PC_W(PC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pm_addr(pm_addr), .pm_rdata(pm_rdata),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .skip_req(skip_req),
    .phase(phase), .ir(ir), .flush(flush), .ext_cycle(ext_cycle), .exec_en(exec_en),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe));

  int n_checks = 0;
  int n_fail = 0;
  bit summary_done = 0;

  // Reference model state
  logic [PC_W-1:0] m_pc;
  logic [15:0]     m_ir;
  logic            m_fl, m_ext;
  int              m_ph;
  string           m_why;

  function automatic bit ref_long(input logic [15:0] w);
    return (w[15:14] == 2'b11) && ((w[13:12] == 2'b00) || (w[13:10] == 4'b1011));
  endfunction

  function automatic bit ref_exec(input logic [15:0] w, input logic fl, input logic ex);
    return !(fl || ex || (w[15:12] == 4'hF));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Compare, drive, advance model, then move to the next falling edge.
  task automatic step(input logic rv, input logic [PC_W-1:0] tg, input logic sk);
    bit en, tr, ts;
    logic [3:0] ph_exp;
    ph_exp = 4'b0001 << m_ph;
    en = ref_exec(m_ir, m_fl, m_ext);
    chk("R2 phase", phase, ph_exp);
    chk({m_why, " pm_addr"}, pm_addr, m_pc);
    chk("R3 addr lsb", pm_addr[0], 1'b0);
    chk({m_why, " ir"}, ir, m_ir);
    chk({m_why, " flush"}, flush, m_fl);
    chk("R7 ext_cycle", ext_cycle, m_ext);
    chk("R8 exec_en", exec_en, en);
    chk("R10 rd_strobe", rd_strobe, en && m_ph == 1);
    chk("R10 wr_strobe", wr_strobe, en && m_ph == 3);
    redirect_valid = rv;
    redirect_pc = tg;
    skip_req = sk;
    if (m_ph == 3) begin
      tr = rv && (en || m_ext);
      ts = !tr && sk && en;
      if (tr) begin
        m_pc = tg & ~PC_W'(1); m_ir = 16'h0000; m_fl = 1; m_ext = 0; m_why = "R5";
      end else if (ts) begin
        m_pc = m_pc + 2; m_ir = 16'h0000; m_fl = 1; m_ext = 0; m_why = "R6";
      end else begin
        m_ext = en && ref_long(m_ir);
        m_ir = prog[m_pc[8:1]]; m_pc = m_pc + 2; m_fl = 0;
        m_why = (rv || sk) ? "R9" : "R4";
      end
      m_ph = 0;
    end else begin
      m_ph++;
    end
    @(negedge clk);
  endtask

  initial begin
    #(70000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) begin
      int unsigned r, k;
      r = $urandom;
      k = r % 8;
      case (k)
        0: prog[i] = {4'hC, r[27:16]};
        1: prog[i] = {6'b111011, r[25:16]};
        2: prog[i] = {4'hF, r[27:16]};
        default: prog[i] = r[31:16];
      endcase
    end
    prog[8'h20] = 16'hC123;
    prog[8'h21] = 16'hF456;
    prog[8'h40] = 16'h1234;

    repeat (3) @(negedge clk);
    // R1: reset values while held
    chk("R1 pm_addr", pm_addr, 0);
    chk("R1 ir", ir, 16'h0000);
    chk("R1 phase", phase, 4'b0001);
    chk("R1 flush", flush, 0);
    chk("R1 ext_cycle", ext_cycle, 0);
    rst_n = 1'b1;
    m_pc = 0; m_ir = 0; m_fl = 0; m_ext = 0; m_ph = 0; m_why = "R1";

    // Directed two-word branch (R5, R9, R11)
    for (int c = 0; c < 6; c++) begin
      for (int p = 0; p < 4; p++) begin
        if (c == 5 && p == 0) begin
          chk("R11 target after three cycles", {ir, exec_en}, {16'h1234, 1'b1});
        end
        if (c == 0 && p == 3)      step(1'b1, 16'h0041, 1'b0);  // odd target
        else if (c == 1 && p == 3) step(1'b1, 16'h0100, 1'b1);  // flush cycle: ignored R9
        else if (c == 2 && p != 3) step(1'b1, 16'h0100, 1'b1);  // not Q4: ignored R9
        else if (c == 3 && p == 3) step(1'b1, 16'h0080, 1'b1);  // operand cycle redirect
        else                       step(1'b0, 16'h0000, 1'b0);
      end
    end

    // Constrained random run
    for (int c = 0; c < 1500; c++) begin
      for (int p = 0; p < 4; p++) begin
        logic rv, sk;
        logic [PC_W-1:0] tg;
        rv = ($urandom % 8) == 0;
        sk = ($urandom % 6) == 0;
        tg = PC_W'($urandom % 512);
        step(rv, tg, sk);
      end
    end
    finish_run();
  end

endmodule